// File: doc/BRIEF.md
# Setup Packet Capture Buffer

This block holds the 8-byte request that arrives in the setup stage of a control transfer, for requests that firmware must service. The packet engine delivers the request as a byte stream framed by a start strobe and one of two end strobes (good or bad). A side flag, sampled with the start strobe, says whether the request is one the hardware services itself. Such requests open no capture, write nothing and leave the setup-received flag alone.

A capture is always accepted, even when the previous request has not been read yet; the old bytes are overwritten. The CPU reads the request one byte at a time through a pop-style port. If a new capture starts while the CPU is part-way through a read, the new capture wins and a sticky invalid-read bit tells firmware to read again after it clears the flag. The interrupt line is the flag gated by an enable input.

The inbound stream uses valid/ready. `rx_ready` is high only while a capture is open and fewer than 8 bytes have been taken. A byte is taken only in a cycle where `rx_valid` and `rx_ready` are both high. The packet engine cannot be stalled mid-packet, so a byte offered while `rx_ready` is low is dropped rather than held. Only a request of exactly 8 taken bytes can raise the flag.

Top module: `setup_capture_buf`

## Requirements
- R1: After reset, `setup_flag`, `invalid_rd`, `irq` and `rx_ready` are 0, and the read pointer is at byte 0. Stored bytes are undefined.
- R2: `rx_start` with `rx_auto`=0 opens a capture. In the next cycle `rx_ready` is 1 and `setup_flag` is 0. Taken bytes are stored in arrival order at byte positions 0 to 7. `rx_start` takes priority over any end strobe or byte offered in the same cycle.
- R3: `rx_ready` is 0 outside an open capture and once 8 bytes have been taken. A byte offered while `rx_ready` is 0 is not stored.
- R4: `rx_start` with `rx_auto`=1 opens no capture and closes any open one. It stores no byte and leaves `setup_flag` and the stored request unchanged.
- R5: `rx_end_ok` during an open capture that has taken exactly 8 bytes sets `setup_flag` in the next cycle.
- R6: `rx_end_bad`, or `rx_end_ok` after fewer than 8 taken bytes, closes the capture and leaves `setup_flag` at 0.
- R7: `rd_data` shows, in the same cycle, the stored byte at the read pointer. Each `rd_pop` advances the pointer by one, and the pointer wraps from byte 7 to byte 0.
- R8: A capture start (`rx_start`, `rx_auto`=0) while the read pointer is not at byte 0 sets `invalid_rd` in the next cycle. The pointer returns to byte 0.
- R9: `flag_clr` clears `setup_flag` and `invalid_rd` and returns the read pointer to byte 0. A flag set in the same cycle wins over the clear. A clear wins over an invalid-read set in the same cycle.
- R10: `irq` is 1 exactly when `setup_flag` and `irq_en` are both 1.
- R11: A completed capture replaces an unread request without waiting for `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Start of a setup reception |
| rx_auto | input | 1 | Request is serviced by hardware (sampled with rx_start) |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Buffer accepts an inbound byte |
| rx_data | input | 8 | Inbound byte |
| rx_end_ok | input | 1 | Reception ended without error |
| rx_end_bad | input | 1 | Reception ended with an error |
| rd_pop | input | 1 | CPU read of one byte; advances the pointer |
| rd_data | output | 8 | Byte at the read pointer |
| flag_clr | input | 1 | Write-1-to-clear of the setup-received flag |
| irq_en | input | 1 | Interrupt enable |
| setup_flag | output | 1 | Setup request received |
| invalid_rd | output | 1 | A read was overtaken by a new capture |
| irq | output | 1 | Interrupt request |

## Verification
`rx_ready`, `setup_flag` and `invalid_rd` are registered. Each responds in the cycle after the clock edge that samples the strobe. `rd_data` and `irq` follow their state and `irq_en` in the same cycle. The bench drives inputs 1 ns after a rising edge and lets its reference model step on that edge. It compares every output at the falling edge, so each result is read after the edge that produced it. Directed checks are sampled 1 ns after the edge that follows the strobe. `rd_data` is compared only when the model knows the byte at the pointer.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned SCB_REQ_BYTES = 8;
  localparam int unsigned SCB_BYTE_W    = 8;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_FILL = 1'b1
  } cap_state_e;
endpackage

// File: rtl/scb_rx_ctrl.sv
module scb_rx_ctrl
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = SCB_REQ_BYTES,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_auto,
  input  logic          rx_valid,
  input  logic          rx_end_ok,
  input  logic          rx_end_bad,
  output logic          rx_ready,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic          cap_begin,
  output logic          cap_done
);
  cap_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          filling;
  logic          full;

  assign filling   = (state_q == CAP_FILL);
  assign full      = (cnt_q == CW'(DEPTH));
  assign cap_begin = rx_start & ~rx_auto;
  assign rx_ready  = filling & ~full;
  // a start in the same cycle drops the offered byte
  assign wr_en     = rx_valid & rx_ready & ~rx_start;
  assign wr_idx    = cnt_q[PW-1:0];
  assign cap_done  = filling & rx_end_ok & ~rx_start & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      cnt_q   <= '0;
    end else if (rx_start) begin
      state_q <= cap_begin ? CAP_FILL : CAP_IDLE;
      cnt_q   <= '0;
    end else if (filling && (rx_end_ok || rx_end_bad)) begin
      state_q <= CAP_IDLE;
    end else if (wr_en) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/scb_store.sv
module scb_store
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = SCB_REQ_BYTES,
  parameter int unsigned DW    = SCB_BYTE_W,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DEPTH*DW-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PW'(g))) slot_q <= wr_data;
    end
    assign flat[g*DW +: DW] = slot_q;
  end

  assign rd_data = flat[int'(rd_idx)*DW +: DW];
endmodule

// File: rtl/scb_cpu_regs.sv
module scb_cpu_regs
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = SCB_REQ_BYTES,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_begin,
  input  logic          cap_done,
  input  logic          rd_pop,
  input  logic          flag_clr,
  input  logic          irq_en,
  output logic [PW-1:0] rd_idx,
  output logic          setup_flag,
  output logic          invalid_rd,
  output logic          irq
);
  logic [PW-1:0] ptr_q;
  logic          flag_q;
  logic          inv_q;
  logic          mid_read;

  assign mid_read = (ptr_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      flag_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      if (flag_clr || cap_begin)  ptr_q <= '0;
      else if (rd_pop)            ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);

      if (cap_done)                   flag_q <= 1'b1;
      else if (flag_clr || cap_begin) flag_q <= 1'b0;

      if (flag_clr)                   inv_q <= 1'b0;
      else if (cap_begin && mid_read) inv_q <= 1'b1;
    end
  end

  assign rd_idx     = ptr_q;
  assign setup_flag = flag_q;
  assign invalid_rd = inv_q;
  assign irq        = flag_q & irq_en;
endmodule

// File: rtl/setup_capture_buf.sv
module setup_capture_buf
  import scb_pkg::*;
#(
  parameter int unsigned DEPTH = SCB_REQ_BYTES,
  parameter int unsigned DW    = SCB_BYTE_W,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_auto,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_end_ok,
  input  logic          rx_end_bad,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic          flag_clr,
  input  logic          irq_en,
  output logic          setup_flag,
  output logic          invalid_rd,
  output logic          irq
);
  logic          wr_en;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] rd_idx;
  logic          cap_begin;
  logic          cap_done;

  scb_rx_ctrl #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_auto(rx_auto),
    .rx_valid(rx_valid), .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad),
    .rx_ready(rx_ready), .wr_en(wr_en), .wr_idx(wr_idx),
    .cap_begin(cap_begin), .cap_done(cap_done)
  );

  scb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rx_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  scb_cpu_regs #(.DEPTH(DEPTH)) u_cpu (
    .clk(clk), .rst_n(rst_n), .cap_begin(cap_begin), .cap_done(cap_done),
    .rd_pop(rd_pop), .flag_clr(flag_clr), .irq_en(irq_en),
    .rd_idx(rd_idx), .setup_flag(setup_flag), .invalid_rd(invalid_rd), .irq(irq)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_start,
  input logic rx_auto,
  input logic rx_ready,
  input logic rx_end_ok,
  input logic flag_clr,
  input logic irq_en,
  input logic setup_flag,
  input logic invalid_rd,
  input logic irq
);
  // R4
  auto_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start && rx_auto |=> !rx_ready);

  // R2
  cap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start && !rx_auto |=> rx_ready && !setup_flag);

  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_flag) |-> $past(rx_end_ok && !rx_start));

  // R8
  inv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalid_rd) |-> $past(rx_start && !rx_auto && !flag_clr));

  // R9
  clr_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !invalid_rd);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind setup_capture_buf scb_checker u_scb_chk (.*);

// File: tb/setup_capture_buf_tb_top.sv
`timescale 1ns/1ps
module setup_capture_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 0, rx_auto = 0, rx_valid = 0, rx_end_ok = 0, rx_end_bad = 0;
  logic [7:0] rx_data = '0;
  logic rd_pop = 0, flag_clr = 0, irq_en = 0;
  logic rx_ready, setup_flag, invalid_rd, irq;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  setup_capture_buf dut_i (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_auto(rx_auto),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad), .rd_pop(rd_pop),
    .rd_data(rd_data), .flag_clr(flag_clr), .irq_en(irq_en),
    .setup_flag(setup_flag), .invalid_rd(invalid_rd), .irq(irq)
  );

  int vecs = 0, errs = 0, cycles = 0;
  bit done = 0;

  // behavioural reference model
  int  m_open, m_cnt, m_flag, m_inv, m_ptr;
  byte m_mem [8];
  bit  m_known [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_cnt = 0; m_flag = 0; m_inv = 0; m_ptr = 0;
      foreach (m_known[i]) m_known[i] = 0;
    end else begin
      bit cb, rdy, wr, fin;
      cb  = rx_start && !rx_auto;
      rdy = (m_open != 0) && m_cnt < 8;
      wr  = rx_valid && rdy && !rx_start;
      fin = (m_open != 0) && rx_end_ok && !rx_start && m_cnt == 8;
      if (wr) begin m_mem[m_cnt] = rx_data; m_known[m_cnt] = 1; end
      if (flag_clr) m_inv = 0;
      else if (cb && m_ptr != 0) m_inv = 1;
      if (flag_clr || cb) m_ptr = 0;
      else if (rd_pop) m_ptr = (m_ptr + 1) % 8;
      if (fin) m_flag = 1;
      else if (flag_clr || cb) m_flag = 0;
      if (rx_start) begin m_open = cb; m_cnt = 0; end
      else if ((m_open != 0) && (rx_end_ok || rx_end_bad)) m_open = 0;
      else if (wr) m_cnt++;
    end
  end

  task automatic check(string tag, int got, int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 rx_ready", rx_ready, (m_open != 0 && m_cnt < 8) ? 1 : 0);
      check("R5 setup_flag", setup_flag, m_flag);
      check("R8 invalid_rd", invalid_rd, m_inv);
      check("R10 irq", irq, (m_flag != 0 && irq_en) ? 1 : 0);
      if (m_known[m_ptr]) check("R7 rd_data", rd_data, int'(m_mem[m_ptr]) & 8'hff);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errs++;
      $display("FAIL watchdog expired got=%0d exp<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // one reception: n bytes from base, ending good or bad
  task automatic recv(bit auto_req, logic [7:0] base, int n, bit good);
    rx_start = 1; rx_auto = auto_req; cyc();
    rx_start = 0; rx_auto = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = base + 8'(i); cyc();
    end
    rx_valid = 0;
    if (good) rx_end_ok = 1; else rx_end_bad = 1;
    cyc();
    rx_end_ok = 0; rx_end_bad = 0;
  endtask

  task automatic read_all(string tag, logic [7:0] base);
    for (int i = 0; i < 8; i++) begin
      check(tag, rd_data, base + 8'(i));
      rd_pop = 1; cyc(); rd_pop = 0;
    end
  endtask

  task automatic clear();
    flag_clr = 1; cyc(); flag_clr = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; #1;
    check("R1 flag", setup_flag, 0);
    check("R1 invalid", invalid_rd, 0);
    check("R1 irq", irq, 0);
    check("R1 ready", rx_ready, 0);
    cyc();

    irq_en = 1;
    recv(0, 8'h10, 8, 1);
    check("R5 flag after 8 good bytes", setup_flag, 1);
    check("R10 irq enabled", irq, 1);
    read_all("R2 stored order", 8'h10);
    check("R7 pointer wrap", rd_data, 8'h10);
    irq_en = 0; #1;
    check("R10 irq masked", irq, 0);
    clear();
    check("R9 clear flag", setup_flag, 0);

    recv(0, 8'h20, 8, 1);
    recv(1, 8'h90, 8, 1);
    check("R4 auto keeps flag", setup_flag, 1);
    check("R4 auto keeps data", rd_data, 8'h20);
    clear();

    recv(0, 8'h30, 8, 0);
    check("R6 bad end", setup_flag, 0);
    recv(0, 8'h38, 5, 1);
    check("R6 short request", setup_flag, 0);

    recv(0, 8'h40, 8, 1);
    recv(0, 8'h50, 8, 1);
    check("R11 overwrite flag", setup_flag, 1);
    read_all("R11 overwrite data", 8'h50);
    clear();

    rx_start = 1; cyc(); rx_start = 0;
    check("R2 ready after start", rx_ready, 1);
    for (int i = 0; i < 10; i++) begin
      rx_valid = 1; rx_data = 8'h60 + 8'(i); cyc();
    end
    rx_valid = 0;
    check("R3 ready low when full", rx_ready, 0);
    rx_end_ok = 1; cyc(); rx_end_ok = 0;
    check("R3 flag after extra bytes", setup_flag, 1);
    read_all("R3 extra bytes dropped", 8'h60);

    for (int i = 0; i < 3; i++) begin rd_pop = 1; cyc(); end
    rd_pop = 0;
    recv(0, 8'h70, 8, 1);
    check("R8 invalid after overtaken read", invalid_rd, 1);
    check("R8 pointer back to 0", rd_data, 8'h70);
    clear();
    check("R9 clear invalid", invalid_rd, 0);

    rx_start = 1; cyc(); rx_start = 0;
    for (int i = 0; i < 8; i++) begin rx_valid = 1; rx_data = 8'h80 + 8'(i); cyc(); end
    rx_valid = 0; rx_end_ok = 1; flag_clr = 1; cyc();
    rx_end_ok = 0; flag_clr = 0;
    check("R9 set beats clear", setup_flag, 1);

    rx_start = 1; rx_end_ok = 1; cyc(); rx_start = 0; rx_end_ok = 0;
    check("R2 start beats end", setup_flag, 0);
    check("R2 capture open", rx_ready, 1);
    rx_end_bad = 1; cyc(); rx_end_bad = 0;
    cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule